// File: doc/BRIEF.md
# Depth-Cascadable FIFO Slice

This block is one slice of a first-in/first-out buffer. Several identical slices can be joined in a ring to get more depth than one slice stores. All slices in the ring share the same write strobe, write data, read strobe and reset. A slice stores a write only while it owns the write token, and returns data only while it owns the read token. Both tokens start at the slice whose first-load input is held low.

When a slice stores a word in its last physical location, it passes the write token to the next slice over its expansion output. It does the same with the read token when it reads out its last physical location. The expansion output is an active-low single-cycle pulse with a direction bit beside it. The slice that receives the pulse may act on a strobe in that same cycle, so the hand-over costs no bubble. Each slice drives its own active-low empty and full flags. Logic outside the slices combines them into chain flags: the chain is empty only when every slice is empty, and full only when every slice is full. The read data of the slices are merged by their valid strobes.

If a slice sees its expansion input low throughout reset, it runs in single-device mode. In that mode it owns both tokens permanently, its pointers wrap around its own storage, and it never pulses its expansion output.

Top module: `casc_fifo_slice`

## Requirements
- R1: After a synchronous reset, every slice has empty_n=0, full_n=1 and xout_n=1, and only the slice with first_load_n=0 owns both tokens.
- R2: A write strobe is stored only by a slice that owns the write token, or that sees xin_n=0 with xin_dir=0 in that same cycle. Every other slice ignores the write, and its empty_n stays unchanged.
- R3: A write to a full slice is ignored. A read from an empty slice is ignored and gives no rd_valid. When a slice is full and sees both strobes, only the read takes effect.
- R4: A write stored in the last physical location (address DEPTH-1) drives xout_n=0 with xout_dir=0 for exactly the next cycle. In that same cycle the slice gives up the write token.
- R5: A read from the last physical location drives xout_n=0 with xout_dir=1 for exactly the next cycle. In that same cycle the slice gives up the read token.
- R6: Across a ring of slices, words come out in the order they were written, including across slice boundaries and wrap-around. The chain empty flag (the OR of the empty_n outputs) is low exactly when the chain holds no words. The chain full flag (the OR of the full_n outputs) is low exactly when the chain holds as many words as the total depth of all its slices.
- R7: A slice whose xin_n is low throughout reset owns both tokens permanently. It behaves as a plain FIFO of DEPTH words and keeps xout_n=1.
- R8: A read that is accepted on a clock edge presents the word on rd_data with rd_valid=1 during the following cycle. rd_valid is 0 in every other cycle.
- R9: empty_n is 0 exactly when the slice holds no words, and full_n is 0 exactly when it holds DEPTH words. Both flags take their new value in the cycle after the edge that changes the word count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| first_load_n | input | 1 | Low on the slice that owns both tokens after reset |
| xin_n | input | 1 | Expansion input, active-low token pulse from the previous slice; held low to select single-device mode |
| xin_dir | input | 1 | Direction of the incoming pulse: 0 passes the write token, 1 passes the read token |
| wr_en | input | 1 | Write strobe, one word per cycle |
| wr_data | input | DATA_W | Write data |
| rd_en | input | 1 | Read strobe, one word per cycle |
| rd_data | output | DATA_W | Registered read data |
| rd_valid | output | 1 | High for the cycle in which rd_data holds a word read by this slice |
| empty_n | output | 1 | Active-low empty flag |
| full_n | output | 1 | Active-low full flag |
| xout_n | output | 1 | Expansion output, active-low single-cycle token pulse |
| xout_dir | output | 1 | Direction of the outgoing pulse: 0 for the write token, 1 for the read token |

## Verification
The hardest situation to reach is a token hand-over in which the very next strobe has to be taken by the slice that is receiving the pulse, while the slice giving it up is already full or empty. A second hard case is a write token that comes back around the ring to a slice still holding unread data. The bench joins three four-word slices in a ring and drives writes back to back across the first boundary. It then runs pseudo-random phases of heavy writing, heavy reading, balanced traffic and writing into a full chain, so the tokens go around the ring several times while the chain is full, empty and in between. A fourth slice, with its expansion input tied low, receives the same strobes and is checked against a model of a plain four-word FIFO.

// File: rtl/casc_fifo_pkg.sv
package casc_fifo_pkg;
  // Direction carried alongside the expansion pulse.
  typedef enum logic {
    XDIR_WR = 1'b0,
    XDIR_RD = 1'b1
  } xdir_e;
endpackage

// File: rtl/cf_token_ctl.sv
module cf_token_ctl
  import casc_fifo_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic first_load_n,
  input  logic xin_n,
  input  logic xin_dir,
  input  logic wr_last,
  input  logic rd_last,
  output logic solo_mode,
  output logic wr_own,
  output logic rd_own,
  output logic xout_n,
  output logic xout_dir
);
  logic wtok, rtok;
  logic w_grant, r_grant;

  // A token arriving this cycle is usable at once (no bubble at hand-over).
  assign w_grant = !solo_mode && !xin_n && (xin_dir == XDIR_WR);
  assign r_grant = !solo_mode && !xin_n && (xin_dir == XDIR_RD);
  assign wr_own  = wtok || w_grant;
  assign rd_own  = rtok || r_grant;

  always_ff @(posedge clk) begin
    if (rst) begin
      // Expansion input held low during reset selects single-device mode.
      solo_mode <= !xin_n;
      wtok      <= !first_load_n || !xin_n;
      rtok      <= !first_load_n || !xin_n;
      xout_n    <= 1'b1;
      xout_dir  <= XDIR_WR;
    end else begin
      xout_n <= 1'b1;
      if (!solo_mode) begin
        if (wr_last) begin
          wtok     <= 1'b0;
          xout_n   <= 1'b0;
          xout_dir <= XDIR_WR;
        end else if (w_grant) begin
          wtok <= 1'b1;
        end
        // A write-last and a read-last cannot coincide: equal pointers
        // mean the slice is either empty or full.
        if (rd_last) begin
          rtok     <= 1'b0;
          xout_n   <= 1'b0;
          xout_dir <= XDIR_RD;
        end else if (r_grant) begin
          rtok <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/cf_ptr_ctl.sv
module cf_ptr_ctl #(
  parameter int DEPTH = 16,
  localparam int ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_req,
  input  logic              rd_req,
  output logic              wr_go,
  output logic              rd_go,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              wr_last,
  output logic              rd_last,
  output logic              empty_n,
  output logic              full_n
);
  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0]  CAP  = CNT_W'(DEPTH);

  logic [CNT_W-1:0] count, count_nxt;

  assign wr_go   = wr_req && full_n;
  assign rd_go   = rd_req && empty_n;
  assign wr_last = wr_go && (wr_addr == LAST);
  assign rd_last = rd_go && (rd_addr == LAST);

  always_comb begin
    count_nxt = count + CNT_W'(wr_go) - CNT_W'(rd_go);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_addr <= '0;
      rd_addr <= '0;
      count   <= '0;
      empty_n <= 1'b0;
      full_n  <= 1'b1;
    end else begin
      if (wr_go) wr_addr <= (wr_addr == LAST) ? '0 : wr_addr + 1'b1;
      if (rd_go) rd_addr <= (rd_addr == LAST) ? '0 : rd_addr + 1'b1;
      count   <= count_nxt;
      empty_n <= (count_nxt != '0);
      full_n  <= (count_nxt != CAP);
    end
  end
endmodule

// File: rtl/cf_ram.sv
module cf_ram #(
  parameter int DATA_W = 9,
  parameter int DEPTH  = 16,
  localparam int ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid
);
  logic [DATA_W-1:0] mem [DEPTH];

  // Simple dual-port array with a registered read port.
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end

  always_ff @(posedge clk) begin
    if (rst) rvalid <= 1'b0;
    else     rvalid <= re;
  end
endmodule

// File: rtl/casc_fifo_slice.sv
module casc_fifo_slice #(
  parameter int DATA_W = 9,
  parameter int DEPTH  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              first_load_n,
  input  logic              xin_n,
  input  logic              xin_dir,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              empty_n,
  output logic              full_n,
  output logic              xout_n,
  output logic              xout_dir
);
  localparam int ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic              solo_mode;
  logic              wr_own, rd_own;
  logic              wr_go, rd_go;
  logic              wr_last, rd_last;
  logic [ADDR_W-1:0] wr_addr, rd_addr;

  cf_token_ctl u_tok (
    .clk         (clk),
    .rst         (rst),
    .first_load_n(first_load_n),
    .xin_n       (xin_n),
    .xin_dir     (xin_dir),
    .wr_last     (wr_last),
    .rd_last     (rd_last),
    .solo_mode   (solo_mode),
    .wr_own      (wr_own),
    .rd_own      (rd_own),
    .xout_n      (xout_n),
    .xout_dir    (xout_dir)
  );

  cf_ptr_ctl #(.DEPTH(DEPTH)) u_ptr (
    .clk    (clk),
    .rst    (rst),
    .wr_req (wr_en && wr_own),
    .rd_req (rd_en && rd_own),
    .wr_go  (wr_go),
    .rd_go  (rd_go),
    .wr_addr(wr_addr),
    .rd_addr(rd_addr),
    .wr_last(wr_last),
    .rd_last(rd_last),
    .empty_n(empty_n),
    .full_n (full_n)
  );

  cf_ram #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_ram (
    .clk   (clk),
    .rst   (rst),
    .we    (wr_go),
    .waddr (wr_addr),
    .wdata (wr_data),
    .re    (rd_go),
    .raddr (rd_addr),
    .rdata (rd_data),
    .rvalid(rd_valid)
  );
endmodule

// File: rtl/casc_fifo_slice_chk.sv
module casc_fifo_slice_chk (
  input logic clk,
  input logic rst,
  input logic wr_en,
  input logic rd_en,
  input logic rd_valid,
  input logic empty_n,
  input logic full_n,
  input logic xout_n,
  input logic xout_dir,
  input logic solo_mode
);
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
    (!full_n && !rd_en) |=> !full_n);

  p_no_underflow_r3: assert property (@(posedge clk) disable iff (rst)
    (!empty_n && !wr_en) |=> (!empty_n && !rd_valid));

  p_flags_exclusive_r9: assert property (@(posedge clk) disable iff (rst)
    !(!empty_n && !full_n));

  p_wr_pulse_single_r4: assert property (@(posedge clk) disable iff (rst)
    (!xout_n && !xout_dir) |=> !(!xout_n && !xout_dir));

  p_pulse_needs_strobe_r5: assert property (@(posedge clk) disable iff (rst)
    !xout_n |-> $past(wr_en || rd_en));

  p_valid_after_read_r8: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> $past(rd_en));

  p_solo_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    solo_mode |-> xout_n);
endmodule

bind casc_fifo_slice casc_fifo_slice_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .wr_en    (wr_en),
  .rd_en    (rd_en),
  .rd_valid (rd_valid),
  .empty_n  (empty_n),
  .full_n   (full_n),
  .xout_n   (xout_n),
  .xout_dir (xout_dir),
  .solo_mode(solo_mode)
);

// File: tb/casc_fifo_slice_bench.sv
`timescale 1ns/1ps
module casc_fifo_slice_bench;
  localparam int DW  = 9;
  localparam int D   = 4;
  localparam int CAP = 3 * D;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [DW-1:0] wr_data = '0;

  logic [2:0] en, fn, xo, xd, vld;
  logic [DW-1:0] rdv [3];
  logic s_en, s_fn, s_xo, s_xd, s_vld;
  logic [DW-1:0] s_rd;

  always #4 clk = ~clk;

  casc_fifo_slice #(.DATA_W(DW), .DEPTH(D)) u_casc_fifo_slice (
    .clk(clk), .rst(rst), .first_load_n(1'b0), .xin_n(xo[2]), .xin_dir(xd[2]),
    .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rd_data(rdv[0]),
    .rd_valid(vld[0]), .empty_n(en[0]), .full_n(fn[0]), .xout_n(xo[0]), .xout_dir(xd[0]));
  casc_fifo_slice #(.DATA_W(DW), .DEPTH(D)) u_slice1 (
    .clk(clk), .rst(rst), .first_load_n(1'b1), .xin_n(xo[0]), .xin_dir(xd[0]),
    .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rd_data(rdv[1]),
    .rd_valid(vld[1]), .empty_n(en[1]), .full_n(fn[1]), .xout_n(xo[1]), .xout_dir(xd[1]));
  casc_fifo_slice #(.DATA_W(DW), .DEPTH(D)) u_slice2 (
    .clk(clk), .rst(rst), .first_load_n(1'b1), .xin_n(xo[1]), .xin_dir(xd[1]),
    .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rd_data(rdv[2]),
    .rd_valid(vld[2]), .empty_n(en[2]), .full_n(fn[2]), .xout_n(xo[2]), .xout_dir(xd[2]));
  casc_fifo_slice #(.DATA_W(DW), .DEPTH(D)) u_solo (
    .clk(clk), .rst(rst), .first_load_n(1'b0), .xin_n(1'b0), .xin_dir(1'b0),
    .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rd_data(s_rd),
    .rd_valid(s_vld), .empty_n(s_en), .full_n(s_fn), .xout_n(s_xo), .xout_dir(s_xd));

  logic c_empty_n, c_full_n, c_valid;
  logic [DW-1:0] c_data;
  assign c_empty_n = |en;
  assign c_full_n  = |fn;
  assign c_valid   = |vld;
  assign c_data    = (vld[0] ? rdv[0] : '0) | (vld[1] ? rdv[1] : '0) | (vld[2] ? rdv[2] : '0);

  int checks = 0, failures = 0;
  int wp_cnt = 0, rp_cnt = 0, solo_pulses = 0;
  int wr_acc = 0, rd_acc = 0;
  bit done = 0, saw_full = 0, saw_empty_again = 0;
  logic [DW-1:0] qc[$];
  logic [DW-1:0] qs[$];
  logic [DW-1:0] seq = '0;
  logic [31:0] lcg = 32'h1234_5678;

  always @(posedge clk) begin
    if (!rst) begin
      for (int k = 0; k < 3; k++)
        if (!xo[k]) begin
          if (xd[k]) rp_cnt++;
          else       wp_cnt++;
        end
      if (!s_xo) solo_pulses++;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input logic w, input logic r);
    logic acc_w, acc_r, s_w, s_r;
    logic [DW-1:0] exp_c, exp_s;
    exp_c = '0; exp_s = '0;
    wr_en = w; rd_en = r; wr_data = seq;
    acc_r = r && (qc.size() > 0);
    acc_w = w && (qc.size() < CAP);
    if (acc_r) begin exp_c = qc.pop_front(); rd_acc++; end
    if (acc_w) begin qc.push_back(seq); wr_acc++; end
    s_r = r && (qs.size() > 0);
    s_w = w && (qs.size() < D);
    if (s_r) exp_s = qs.pop_front();
    if (s_w) qs.push_back(seq);
    if (w) seq = seq + 1'b1;
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
    check("R8 chain rd_valid", 32'(c_valid), 32'(acc_r));
    if (acc_r) check("R6 chain order", 32'(c_data), 32'(exp_c));
    check("R6 chain empty", 32'(c_empty_n), 32'(qc.size() != 0));
    check("R6 chain full", 32'(c_full_n), 32'(qc.size() != CAP));
    check("R7 solo rd_valid", 32'(s_vld), 32'(s_r));
    if (s_r) check("R7 solo order", 32'(s_rd), 32'(exp_s));
    check("R9 solo empty", 32'(s_en), 32'(qs.size() != 0));
    check("R9 solo full", 32'(s_fn), 32'(qs.size() != D));
    if (qc.size() == CAP) saw_full = 1;
    if (saw_full && qc.size() == 0) saw_empty_again = 1;
  endtask

  task automatic finish_run();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1: reset state of every slice
    check("R1 empty_n", 32'(en), 32'b000);
    check("R1 full_n", 32'(fn), 32'b111);
    check("R1 xout_n", 32'(xo), 32'b111);
    check("R1 solo empty_n", 32'(s_en), 32'b0);
    // R2: only the first-load slice takes the first write
    step(1'b1, 1'b0);
    check("R2 token at first slice", 32'(en), 32'b001);
    step(1'b1, 1'b0);
    step(1'b1, 1'b0);
    step(1'b1, 1'b0);
    // R4: write into last location pulses expansion out with dir 0
    check("R4 xout_n low", 32'(xo[0]), 32'b0);
    check("R4 xout_dir write", 32'(xd[0]), 32'b0);
    check("R9 slice0 full", 32'(fn[0]), 32'b0);
    step(1'b1, 1'b0);
    check("R4 pulse one cycle", 32'(xo[0]), 32'b1);
    check("R2 zero-bubble hand-over", 32'(en), 32'b011);
    check("R7 solo xout quiet", 32'(s_xo), 32'b1);
    // R5: reading out slice0 last location pulses with dir 1
    step(1'b0, 1'b1);
    step(1'b0, 1'b1);
    step(1'b0, 1'b1);
    step(1'b0, 1'b1);
    check("R5 xout_n low", 32'(xo[0]), 32'b0);
    check("R5 xout_dir read", 32'(xd[0]), 32'b1);
    step(1'b0, 1'b1);
    check("R3 slice0 stays empty", 32'(en[0]), 32'b0);
    // Pseudo-random phases: fill, drain, balanced, overflow
    for (int i = 0; i < 720; i++) begin
      int ph;
      logic w, r;
      ph = (i / 60) % 4;
      lcg = lcg * 32'd1103515245 + 32'd12345;
      case (ph)
        0: begin w = (lcg[17:16] != 2'd0); r = (lcg[21:20] == 2'd0); end
        1: begin w = (lcg[17:16] == 2'd0); r = (lcg[21:20] != 2'd0); end
        2: begin w = lcg[18];              r = lcg[22];              end
        default: begin w = 1'b1; r = 1'b0; end
      endcase
      step(w, r);
    end
    // R3: drain past empty
    for (int i = 0; i < CAP + 4; i++) step(1'b0, 1'b1);
    step(1'b0, 1'b0);
    step(1'b0, 1'b0);
    check("R6 reached full then empty", 32'(saw_empty_again), 32'b1);
    check("R4 write pulse total", 32'(wp_cnt), 32'(wr_acc / D));
    check("R5 read pulse total", 32'(rp_cnt), 32'(rd_acc / D));
    check("R7 solo pulse total", 32'(solo_pulses), 32'b0);
    done = 1;
    finish_run();
  end

  initial begin
    #200000;
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=1 expected=0");
      finish_run();
    end
  end
endmodule